// File: doc/BRIEF.md
# RAMDAC host register interface

This block is the processor-facing register file of a true-colour RAMDAC. A host writes and reads bytes through a 4-bit register select. The select is formed from two address lines and two extra select pins. Behind the select sit several parts:

- a bank of indexed control registers;
- a small cursor colour store loaded three bytes at a time;
- 12-bit cursor X and Y position registers;
- byte access to a 1024-byte cursor pattern RAM.

The colour store and the pattern RAM share one auto-incrementing address pointer.

The decoded control state is presented as plain outputs for the pixel side of the chip: the pixel depth in bits, the palette width flag, the cursor mode and the cursor position. Writes take effect on the clock edge where the write strobe is high. Read data is registered and appears one cycle after the read strobe. If both strobes are high together, the write is performed and the read is dropped.

Top module: `ramdac_hostif`

## Requirements
- R1: The register select is {rs3, rs2, addr[1:0]}. After reset the outputs are: pix_bpp 8, pal_8bit 0, cursor_mode 0, cursor_x 0, cursor_y 0, rdata 0xFF. After reset, reading through the indexed port returns 0x06 for index 0x0F, 0x80 for 0x18, 0x98 for 0x19, 0x18 for 0x39 and 0x00 for 0x06.
- R2: Read data for a read strobe is loaded on that clock edge and stays unchanged until the next read strobe.
- R3: A write to select 0000 latches the byte as the index of the indexed data port at select 1010. That port then reads and writes the register with that index: 0x06, 0x0F, 0x18, 0x19, 0x1C, 0x1D, 0x1E or 0x39.
- R4: The indexed port returns 0x26 for index 0x3F and 0x00 for index 0x01. It returns 0xFF for any other index not listed in R3. Reads of selects 0000, 0001, 0010, 0100, 0110 and 1000 return 0xFF.
- R5: A write to select 0000 or 0100 loads the shared pointer and restarts the colour byte counter. Writes to select 0101 are taken as red, then green, then blue. The third byte commits the colour to slot pointer[1:0], and the pointer then advances within its low 8 bits (0xFF goes to 0x00). An incomplete sequence commits nothing.
- R6: A write to select 0011 or 0111 loads the pointer with the byte plus one and restarts the byte counter. A read of either select returns the pointer's low byte. A read of select 0101 returns red, green, then blue of slot (pointer−1)[1:0], and the pointer advances by one after blue.
- R7: Bit 3 of index 0x1E sets 8-bit palette width (pal_8bit = 1). When the bit is clear, colour reads are masked to their low 6 bits.
- R8: Select 1011 accesses the pattern RAM. A write stores the byte at the pointer. A read returns the byte at pointer−1. Every access advances the 10-bit pointer by one, wrapping from 1023 to 0.
- R9: Selects 1100/1101 set the low and high bytes of cursor_x, and selects 1110/1111 set those of cursor_y. Only the low nibble of a high byte is kept, and a high-byte read returns that nibble with zero upper bits.
- R10: A write to index 0x06 always sets cursor_mode to the byte's bits [1:0]. A write to select 1001 is stored and read back at select 1001. It sets cursor_mode to its bits [1:0] only when bit 7 of index 0x06 is 1.
- R11: pix_bpp is decoded from index 0x18 (tc) and index 0x19 (mx):
  - if tc[7] is 1: 8 when mx[3] is 1, else 4;
  - if tc[7] is 0, by tc[3:0]: 1, 3 or 5 give 16; 4 gives 15; 6 or 7 give 24 when tc[4] is 1, else 32; 0xE or 0xF give 24; every other value gives 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 2 | Low register select bits |
| rs2 | input | 1 | Register select bit 2 |
| rs3 | input | 1 | Register select bit 3 |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Registered read byte |
| pix_bpp | output | 6 | Decoded pixel depth in bits |
| pal_8bit | output | 1 | Palette width flag, 1 for 8-bit |
| cursor_mode | output | 2 | Cursor display mode |
| cursor_x | output | 12 | Cursor X position |
| cursor_y | output | 12 | Cursor Y position |

## Verification
Each register, pointer and output updates on the clock edge where its strobe is high. The bench raises the strobe at a falling edge and lowers it at the next falling edge, and it samples the decoded outputs at that second falling edge. Read data is loaded on the strobed rising edge, so each read is sampled at the falling edge that ends its strobe and is never sampled later. After reset is removed, the internal reset releases two rising edges later, so the bench waits three cycles before its first check. The pointer side effects of R5, R6 and R8 are checked through the read-index readback. The pattern RAM check sweeps all 1024 bytes, and the depth check sweeps all 256 values of tc under both states of mx[3].

// File: rtl/ramdac_pkg.sv
package ramdac_pkg;

  localparam logic [3:0] SEL_WIDX  = 4'h0;
  localparam logic [3:0] SEL_RIDX  = 4'h3;
  localparam logic [3:0] SEL_XWIDX = 4'h4;
  localparam logic [3:0] SEL_COLOR = 4'h5;
  localparam logic [3:0] SEL_XRIDX = 4'h7;
  localparam logic [3:0] SEL_DCUR  = 4'h9;
  localparam logic [3:0] SEL_IDATA = 4'hA;
  localparam logic [3:0] SEL_PRAM  = 4'hB;
  localparam logic [3:0] SEL_XLO   = 4'hC;
  localparam logic [3:0] SEL_XHI   = 4'hD;
  localparam logic [3:0] SEL_YLO   = 4'hE;
  localparam logic [3:0] SEL_YHI   = 4'hF;

  localparam logic [7:0] IX_REV   = 8'h01;
  localparam logic [7:0] IX_CCTL  = 8'h06;
  localparam logic [7:0] IX_LATCH = 8'h0F;
  localparam logic [7:0] IX_TRUE  = 8'h18;
  localparam logic [7:0] IX_MUX   = 8'h19;
  localparam logic [7:0] IX_PAGE  = 8'h1C;
  localparam logic [7:0] IX_GEN   = 8'h1D;
  localparam logic [7:0] IX_MISC  = 8'h1E;
  localparam logic [7:0] IX_CLK   = 8'h39;
  localparam logic [7:0] IX_ID    = 8'h3F;

  localparam logic [7:0] RST_LATCH = 8'h06;
  localparam logic [7:0] RST_TRUE  = 8'h80;
  localparam logic [7:0] RST_MUX   = 8'h98;
  localparam logic [7:0] RST_CLK   = 8'h18;
  localparam logic [7:0] ID_BYTE   = 8'h26;
  localparam logic [7:0] REV_BYTE  = 8'h00;
  localparam logic [7:0] IDLE_BYTE = 8'hFF;

  typedef struct packed {
    logic [7:0] red;
    logic [7:0] grn;
    logic [7:0] blu;
  } rgb_t;

  function automatic logic [5:0] depth_of(input logic [7:0] tc, input logic [7:0] mx);
    logic [5:0] d;
    if (tc[7]) begin
      d = mx[3] ? 6'd8 : 6'd4;
    end else begin
      case (tc[3:0])
        4'h1, 4'h3, 4'h5: d = 6'd16;
        4'h4:             d = 6'd15;
        4'h6, 4'h7:       d = tc[4] ? 6'd24 : 6'd32;
        4'hE, 4'hF:       d = 6'd24;
        default:          d = 6'd8;
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/hostif_ptr.sv
module hostif_ptr #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_wr,
  input  logic          idx_pre,
  input  logic [7:0]    idx_val,
  input  logic          col_wr,
  input  logic          col_rd,
  input  logic          ram_step,
  output logic [AW-1:0] ptr,
  output logic [1:0]    phase
);

  logic [AW-1:0] ptr_q, ptr_d;
  logic [1:0]    ph_q, ph_d;
  logic          ptr_en;
  logic [7:0]    lo_inc;

  assign lo_inc = ptr_q[7:0] + 8'd1;
  assign ptr_en = idx_wr | col_wr | col_rd | ram_step;

  always_comb begin
    ptr_d = ptr_q;
    ph_d  = ph_q;
    if (idx_wr) begin
      ptr_d = AW'(idx_val) + (idx_pre ? AW'(1) : AW'(0));
      ph_d  = 2'd0;
    end else if (col_wr) begin
      if (ph_q == 2'd2) begin
        ptr_d = AW'(lo_inc);
        ph_d  = 2'd0;
      end else begin
        ph_d = ph_q + 2'd1;
      end
    end else if (col_rd) begin
      if (ph_q == 2'd2) begin
        ptr_d = ptr_q + AW'(1);
        ph_d  = 2'd0;
      end else begin
        ph_d = ph_q + 2'd1;
      end
    end else if (ram_step) begin
      ptr_d = ptr_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      ph_q  <= 2'd0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
      ph_q  <= ph_d;
    end
  end

  assign ptr   = ptr_q;
  assign phase = ph_q;

  assert_phase_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q != 2'd3);

  assert_preinc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && idx_pre) |=> (ptr_q == AW'({1'b0, $past(idx_val)} + 9'd1)));

  assert_ram_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_step && !idx_wr && !col_wr && !col_rd) |=> (ptr_q == $past(ptr_q) + AW'(1)));

endmodule

// File: rtl/hostif_curpal.sv
module hostif_curpal
  import ramdac_pkg::*;
#(
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          col_wr,
  input  logic [7:0]    wdata,
  input  logic [1:0]    phase,
  input  logic [SW-1:0] slot_ptr,
  input  logic          wide,
  output logic [7:0]    rd_byte
);

  localparam int NSLOT = 1 << SW;

  rgb_t          slot_q [NSLOT];
  logic [7:0]    red_q, grn_q;
  logic          commit;
  logic [SW-1:0] rd_slot;
  rgb_t          rd_ent;
  logic [7:0]    raw;

  assign commit = col_wr && (phase == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      red_q <= '0;
      grn_q <= '0;
    end else if (col_wr) begin
      if (phase == 2'd0) red_q <= wdata;
      if (phase == 2'd1) grn_q <= wdata;
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic hit;
    assign hit = commit && (slot_ptr == SW'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[s] <= '0;
      end else if (hit) begin
        slot_q[s] <= '{red: red_q, grn: grn_q, blu: wdata};
      end
    end
  end

  assign rd_slot = slot_ptr - SW'(1);
  assign rd_ent  = slot_q[rd_slot];

  always_comb begin
    case (phase)
      2'd0:    raw = rd_ent.red;
      2'd1:    raw = rd_ent.grn;
      default: raw = rd_ent.blu;
    endcase
    rd_byte = wide ? raw : {2'b00, raw[5:0]};
  end

  assert_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (slot_q[$past(slot_ptr)] == {$past(red_q), $past(grn_q), $past(wdata)}));

endmodule

// File: rtl/hostif_curram.sv
module hostif_curram #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          wr,
  input  logic [AW-1:0] ptr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rd_byte
);

  localparam int DEPTH = 1 << AW;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rd_at;

  always_ff @(posedge clk) begin
    if (wr) mem[ptr] <= wdata;
  end

  assign rd_at   = ptr - AW'(1);
  assign rd_byte = mem[rd_at];

endmodule

// File: rtl/hostif_ctl.sv
module hostif_ctl
  import ramdac_pkg::*;
#(
  parameter int POS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       sel,
  input  logic [7:0]       wdata,
  output logic [7:0]       rd_byte,
  output logic [5:0]       pix_bpp,
  output logic             pal_8bit,
  output logic [1:0]       cursor_mode,
  output logic [POS_W-1:0] cursor_x,
  output logic [POS_W-1:0] cursor_y
);

  localparam int HI_W = POS_W - 8;

  logic [7:0] idx_q, cctl_q, latch_q, true_q, mux_q, page_q, gen_q, misc_q, clk_q, dcur_q;
  logic [1:0] mode_q, mode_d;
  logic [POS_W-1:0] cx_q, cx_d, cy_q, cy_d;
  logic ix_wr, idx_en, cctl_en, latch_en, true_en, mux_en, page_en, gen_en, misc_en, clk_en;
  logic dcur_en, mode_en, cx_en, cy_en;
  logic [7:0] ix_rd;

  assign ix_wr    = wr_en && (sel == SEL_IDATA);
  assign idx_en   = wr_en && (sel == SEL_WIDX);
  assign cctl_en  = ix_wr && (idx_q == IX_CCTL);
  assign latch_en = ix_wr && (idx_q == IX_LATCH);
  assign true_en  = ix_wr && (idx_q == IX_TRUE);
  assign mux_en   = ix_wr && (idx_q == IX_MUX);
  assign page_en  = ix_wr && (idx_q == IX_PAGE);
  assign gen_en   = ix_wr && (idx_q == IX_GEN);
  assign misc_en  = ix_wr && (idx_q == IX_MISC);
  assign clk_en   = ix_wr && (idx_q == IX_CLK);
  assign dcur_en  = wr_en && (sel == SEL_DCUR);
  assign mode_en  = cctl_en || (dcur_en && cctl_q[7]);
  assign cx_en    = wr_en && ((sel == SEL_XLO) || (sel == SEL_XHI));
  assign cy_en    = wr_en && ((sel == SEL_YLO) || (sel == SEL_YHI));

  always_comb begin
    mode_d = wdata[1:0];
    cx_d   = cx_q;
    cy_d   = cy_q;
    if (sel == SEL_XLO) cx_d[7:0]       = wdata;
    if (sel == SEL_XHI) cx_d[POS_W-1:8] = wdata[HI_W-1:0];
    if (sel == SEL_YLO) cy_d[7:0]       = wdata;
    if (sel == SEL_YHI) cy_d[POS_W-1:8] = wdata[HI_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      cctl_q  <= '0;
      latch_q <= RST_LATCH;
      true_q  <= RST_TRUE;
      mux_q   <= RST_MUX;
      page_q  <= '0;
      gen_q   <= '0;
      misc_q  <= '0;
      clk_q   <= RST_CLK;
      dcur_q  <= '0;
      mode_q  <= '0;
      cx_q    <= '0;
      cy_q    <= '0;
    end else begin
      if (idx_en)   idx_q   <= wdata;
      if (cctl_en)  cctl_q  <= wdata;
      if (latch_en) latch_q <= wdata;
      if (true_en)  true_q  <= wdata;
      if (mux_en)   mux_q   <= wdata;
      if (page_en)  page_q  <= wdata;
      if (gen_en)   gen_q   <= wdata;
      if (misc_en)  misc_q  <= wdata;
      if (clk_en)   clk_q   <= wdata;
      if (dcur_en)  dcur_q  <= wdata;
      if (mode_en)  mode_q  <= mode_d;
      if (cx_en)    cx_q    <= cx_d;
      if (cy_en)    cy_q    <= cy_d;
    end
  end

  always_comb begin
    case (idx_q)
      IX_REV:   ix_rd = REV_BYTE;
      IX_CCTL:  ix_rd = cctl_q;
      IX_LATCH: ix_rd = latch_q;
      IX_TRUE:  ix_rd = true_q;
      IX_MUX:   ix_rd = mux_q;
      IX_PAGE:  ix_rd = page_q;
      IX_GEN:   ix_rd = gen_q;
      IX_MISC:  ix_rd = misc_q;
      IX_CLK:   ix_rd = clk_q;
      IX_ID:    ix_rd = ID_BYTE;
      default:  ix_rd = IDLE_BYTE;
    endcase
    case (sel)
      SEL_DCUR:  rd_byte = dcur_q;
      SEL_IDATA: rd_byte = ix_rd;
      SEL_XLO:   rd_byte = cx_q[7:0];
      SEL_XHI:   rd_byte = 8'(cx_q[POS_W-1:8]);
      SEL_YLO:   rd_byte = cy_q[7:0];
      SEL_YHI:   rd_byte = 8'(cy_q[POS_W-1:8]);
      default:   rd_byte = IDLE_BYTE;
    endcase
  end

  assign pix_bpp     = depth_of(true_q, mux_q);
  assign pal_8bit    = misc_q[3];
  assign cursor_mode = mode_q;
  assign cursor_x    = cx_q;
  assign cursor_y    = cy_q;

  assert_mode_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (sel == SEL_DCUR) && !cctl_q[7]) |=> $stable(cursor_mode));

  assert_mode_direct_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (sel == SEL_DCUR) && cctl_q[7]) |=> (cursor_mode == $past(wdata[1:0])));

  assert_depth_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_bpp == 6'd4) || (pix_bpp == 6'd8) || (pix_bpp == 6'd15) ||
    (pix_bpp == 6'd16) || (pix_bpp == 6'd24) || (pix_bpp == 6'd32));

endmodule

// File: rtl/ramdac_hostif.sv
module ramdac_hostif
  import ramdac_pkg::*;
#(
  parameter int RAM_AW = 10,
  parameter int POS_W  = 12,
  parameter int SLOT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic             rs2,
  input  logic             rs3,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic [5:0]       pix_bpp,
  output logic             pal_8bit,
  output logic [1:0]       cursor_mode,
  output logic [POS_W-1:0] cursor_x,
  output logic [POS_W-1:0] cursor_y
);

  logic [1:0]        rst_sync;
  logic              rst_i_n;
  logic [3:0]        sel;
  logic              rd_go, idx_wr, idx_pre, col_wr, col_rd, ram_wr, ram_rd;
  logic [RAM_AW-1:0] ptr;
  logic [1:0]        phase;
  logic [7:0]        col_byte, ram_byte, ctl_byte, rd_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  assign sel     = {rs3, rs2, addr};
  assign rd_go   = rd_en && !wr_en;
  assign idx_wr  = wr_en && ((sel == SEL_WIDX) || (sel == SEL_XWIDX) ||
                             (sel == SEL_RIDX) || (sel == SEL_XRIDX));
  assign idx_pre = (sel[1:0] == 2'b11);
  assign col_wr  = wr_en && (sel == SEL_COLOR);
  assign col_rd  = rd_go && (sel == SEL_COLOR);
  assign ram_wr  = wr_en && (sel == SEL_PRAM);
  assign ram_rd  = rd_go && (sel == SEL_PRAM);

  hostif_ptr #(.AW(RAM_AW)) u_ptr (
    .clk(clk), .rst_n(rst_i_n), .idx_wr(idx_wr), .idx_pre(idx_pre), .idx_val(wdata),
    .col_wr(col_wr), .col_rd(col_rd), .ram_step(ram_wr | ram_rd),
    .ptr(ptr), .phase(phase)
  );

  hostif_curpal #(.SW(SLOT_W)) u_pal (
    .clk(clk), .rst_n(rst_i_n), .col_wr(col_wr), .wdata(wdata), .phase(phase),
    .slot_ptr(ptr[SLOT_W-1:0]), .wide(pal_8bit), .rd_byte(col_byte)
  );

  hostif_curram #(.AW(RAM_AW)) u_ram (
    .clk(clk), .wr(ram_wr), .ptr(ptr), .wdata(wdata), .rd_byte(ram_byte)
  );

  hostif_ctl #(.POS_W(POS_W)) u_ctl (
    .clk(clk), .rst_n(rst_i_n), .wr_en(wr_en), .sel(sel), .wdata(wdata),
    .rd_byte(ctl_byte), .pix_bpp(pix_bpp), .pal_8bit(pal_8bit),
    .cursor_mode(cursor_mode), .cursor_x(cursor_x), .cursor_y(cursor_y)
  );

  always_comb begin
    case (sel)
      SEL_RIDX, SEL_XRIDX: rd_next = ptr[7:0];
      SEL_COLOR:           rd_next = col_byte;
      SEL_PRAM:            rd_next = ram_byte;
      SEL_DCUR, SEL_IDATA, SEL_XLO, SEL_XHI, SEL_YLO, SEL_YHI: rd_next = ctl_byte;
      default:             rd_next = IDLE_BYTE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)   rdata <= IDLE_BYTE;
    else if (rd_go) rdata <= rd_next;
  end

  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    !rd_go |=> $stable(rdata));

endmodule

// File: tb/sim_ramdac_hostif.sv
module sim_ramdac_hostif;

  logic clk = 1'b0;
  logic rst_n, wr_en, rd_en, rs2, rs3;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic [5:0] pix_bpp;
  logic pal_8bit;
  logic [1:0] cursor_mode;
  logic [11:0] cursor_x, cursor_y;
  int nchk = 0;
  int nerr = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  ramdac_hostif u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .rs2(rs2), .rs3(rs3), .wdata(wdata), .rdata(rdata), .pix_bpp(pix_bpp),
    .pal_8bit(pal_8bit), .cursor_mode(cursor_mode), .cursor_x(cursor_x),
    .cursor_y(cursor_y)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_sel(input logic [3:0] s);
    {rs3, rs2, addr} = s;
  endtask

  task automatic wr(input logic [3:0] s, input logic [7:0] d);
    put_sel(s); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] s, output logic [7:0] d);
    put_sel(s); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic ix_wr(input logic [7:0] ix, input logic [7:0] d);
    wr(4'h0, ix); wr(4'hA, d);
  endtask

  task automatic ix_rd(input logic [7:0] ix, output logic [7:0] d);
    wr(4'h0, ix); rd(4'hA, d);
  endtask

  function automatic logic [5:0] exp_bpp(input int tc, input int mx);
    int lo;
    if (tc >= 128) return (((mx / 8) % 2) == 1) ? 6'd8 : 6'd4;
    lo = tc % 16;
    if (lo == 1 || lo == 3 || lo == 5) return 6'd16;
    if (lo == 4) return 6'd15;
    if (lo == 6 || lo == 7) return (((tc / 16) % 2) == 1) ? 6'd24 : 6'd32;
    if (lo >= 14) return 6'd24;
    return 6'd8;
  endfunction

  function automatic logic [7:0] colv(input int s, input int c);
    return 8'((s * 53 + c * 17 + 3) % 256);
  endfunction

  function automatic logic [7:0] ramv(input int i);
    return 8'((i * 37 + 5) % 256);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] vals [4];
    logic [7:0] ixs [8];
    logic [3:0] unm [6];
    vals = '{8'h00, 8'h5A, 8'hA5, 8'hFF};
    ixs  = '{8'h06, 8'h0F, 8'h18, 8'h19, 8'h1C, 8'h1D, 8'h1E, 8'h39};
    unm  = '{4'h0, 4'h1, 4'h2, 4'h4, 4'h6, 4'h8};
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wdata = '0; put_sel(4'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 rdata", rdata, 8'hFF);
    chk("R1 pix_bpp", pix_bpp, 6'd8);
    chk("R1 pal_8bit", pal_8bit, 1'b0);
    chk("R1 mode", cursor_mode, 2'd0);
    chk("R1 cursor_x", cursor_x, 12'h000);
    chk("R1 cursor_y", cursor_y, 12'h000);
    ix_rd(8'h0F, v); chk("R1 latch default", v, 8'h06);
    ix_rd(8'h18, v); chk("R1 truecolour default", v, 8'h80);
    ix_rd(8'h19, v); chk("R1 mux default", v, 8'h98);
    ix_rd(8'h39, v); chk("R1 clock default", v, 8'h18);
    ix_rd(8'h06, v); chk("R1 cursor ctl default", v, 8'h00);

    // R2 rdata holds without a read strobe
    ix_rd(8'h3F, v);
    wr(4'h0, 8'h0F);
    @(negedge clk);
    chk("R2 hold", rdata, 8'h26);

    // R4 constants and unmapped selects
    ix_rd(8'h3F, v); chk("R4 id", v, 8'h26);
    ix_rd(8'h01, v); chk("R4 revision", v, 8'h00);
    ix_rd(8'h40, v); chk("R4 unknown index", v, 8'hFF);
    ix_rd(8'h02, v); chk("R4 unknown index 02", v, 8'hFF);
    foreach (unm[k]) begin
      rd(unm[k], v); chk("R4 unmapped select", v, 8'hFF);
    end

    // R3 indexed register sweep, R7 width flag
    foreach (ixs[i]) begin
      foreach (vals[j]) begin
        ix_wr(ixs[i], vals[j]);
        rd(4'hA, v); chk("R3 indexed readback", v, vals[j]);
        if (ixs[i] == 8'h1E) chk("R7 pal_8bit", pal_8bit, vals[j][3]);
      end
    end
    ix_wr(8'h18, 8'h80); ix_wr(8'h19, 8'h98);

    // R5 colour writes into all slots, R6 and R7 readback
    ix_wr(8'h1E, 8'h08);
    wr(4'h0, 8'h00);
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 3; c++) wr(4'h5, colv(s, c));
    rd(4'h3, v); chk("R5 pointer after four slots", v, 8'h04);
    wr(4'h3, 8'h00);
    rd(4'h3, v); chk("R6 preincrement", v, 8'h01);
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 3; c++) begin
        rd(4'h5, v); chk("R6 colour read 8-bit", v, colv(s, c));
      end
    rd(4'h7, v); chk("R6 pointer after reads", v, 8'h05);
    ix_wr(8'h1E, 8'h00);
    wr(4'h7, 8'h00);
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 3; c++) begin
        rd(4'h5, v); chk("R7 colour read 6-bit", v, colv(s, c) & 8'h3F);
      end
    ix_wr(8'h1E, 8'h08);

    // R5 8-bit wrap of the pointer and a partial sequence that commits nothing
    wr(4'h4, 8'hFF);
    wr(4'h5, 8'h11); wr(4'h5, 8'h22); wr(4'h5, 8'h33);
    rd(4'h3, v); chk("R5 wrap to 00", v, 8'h00);
    wr(4'h0, 8'h02);
    wr(4'h5, 8'h99); wr(4'h5, 8'h98);
    wr(4'h3, 8'h02);
    rd(4'h5, v); chk("R5 partial ignored red", v, colv(2, 0));
    rd(4'h5, v); chk("R5 partial ignored green", v, colv(2, 1));
    rd(4'h5, v); chk("R5 partial ignored blue", v, colv(2, 2));
    wr(4'h3, 8'h03);
    rd(4'h5, v); chk("R5 wrap slot red", v, 8'h11);
    rd(4'h5, v); chk("R5 wrap slot green", v, 8'h22);
    rd(4'h5, v); chk("R5 wrap slot blue", v, 8'h33);

    // R8 pattern RAM fill, wrap, readback
    wr(4'h0, 8'h00);
    for (int i = 0; i < 1024; i++) wr(4'hB, ramv(i));
    wr(4'hB, 8'hA5);
    wr(4'h3, 8'h00);
    for (int i = 0; i < 1024; i++) begin
      rd(4'hB, v); chk("R8 pattern byte", v, (i == 0) ? 8'hA5 : ramv(i));
    end
    rd(4'h3, v); chk("R8 pointer wrapped", v, 8'h01);

    // R9 cursor position
    wr(4'hC, 8'h34); wr(4'hD, 8'hAB);
    chk("R9 cursor_x", cursor_x, 12'hB34);
    rd(4'hD, v); chk("R9 x high read", v, 8'h0B);
    rd(4'hC, v); chk("R9 x low read", v, 8'h34);
    wr(4'hE, 8'h7E); wr(4'hF, 8'hF2);
    chk("R9 cursor_y", cursor_y, 12'h27E);
    rd(4'hF, v); chk("R9 y high read", v, 8'h02);
    chk("R9 x untouched", cursor_x, 12'hB34);

    // R10 cursor mode gating
    ix_wr(8'h06, 8'h02);
    chk("R10 indirect sets mode", cursor_mode, 2'd2);
    wr(4'h9, 8'h03);
    chk("R10 direct blocked", cursor_mode, 2'd2);
    rd(4'h9, v); chk("R10 direct readback", v, 8'h03);
    ix_wr(8'h06, 8'h81);
    chk("R10 indirect sets mode 1", cursor_mode, 2'd1);
    wr(4'h9, 8'h03);
    chk("R10 direct allowed", cursor_mode, 2'd3);
    wr(4'h9, 8'hFC);
    chk("R10 direct allowed 0", cursor_mode, 2'd0);

    // R11 depth sweep
    for (int m = 0; m < 2; m++) begin
      ix_wr(8'h19, (m == 0) ? 8'h98 : 8'h90);
      wr(4'h0, 8'h18);
      for (int t = 0; t < 256; t++) begin
        wr(4'hA, 8'(t));
        chk("R11 pix_bpp", pix_bpp, exp_bpp(t, (m == 0) ? 8'h98 : 8'h90));
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule